// File: doc/BRIEF.md
# Flash Algorithm Status Interface

This block sits between a CPU read/command path and a flash array that runs its own program and erase sequences. When the bus hands it a program or erase command while the flash is idle, it starts a busy period and drops the ready line. A programmable cycle count stands in for the cell timing. A control register carries that line as a readable bit. When the line returns high, the block raises a sticky, maskable interrupt.

While a sequence runs in programming mode, reads aimed at the flash return a byte of sequence flags and not array contents. The flags are a data-polling bit, two toggle bits, a time-limit bit and an erase-in-progress bit. Software uses them to follow progress. In ROM-read mode, or when the flash is idle, reads pass the array data straight through.

Top module: `flash_algo_status`

## Requirements
- R1: A program (cmd_kind 1) or erase (cmd_kind 2) command accepted while rdy is 1 makes rdy fall on the next cycle. rdy then stays low for exactly the configured cycle count (cfg_prog_cyc or cfg_erase_cyc), and a count of 0 is treated as 1.
- R2: ctl_rdata bit 0 always equals rdy.
- R3: Each rising edge of rdy sets a pending flag, read on ctl_rdata bit 2. The flag stays set until a control write with ctl_wdata bit 2 high clears it. ctl_wdata bit 1 writes the interrupt enable, read on ctl_rdata bit 1, and irq equals pending AND enable.
- R4: Program and erase commands given while rdy is 0 have no effect on the running sequence, its duration or its flags.
- R5: While busy in programming mode, a halfword read (rd_size 1) or a byte read (rd_size 0) with rd_addr_lsb 1 returns the flag byte in rd_data[7:0] with rd_data[15:8] zero. A word read (rd_size 2) or an even byte read returns zero.
- R6: Flag bit 7 is the complement of bit 7 of the byte being programmed, passed in on cmd_msb. It reads 0 during an erase.
- R7: Flag bit 6 reads 0 on the first flag read of each sequence and inverts after every flag read. Flag bit 2 does the same, but only during an erase, and stays 0 during a program. Flag bits 4, 1 and 0 read 0.
- R8: When rdy is 1 or prog_mode is 0, rd_data equals arr_rdata, and reads made then do not advance the toggle bits.
- R9: Flag bit 5 sets once a busy period has lasted more than cfg_limit cycles. It then stays set across later sequences until a clear command (cmd_kind 3).
- R10: Flag bit 3 reads 1 during an erase and 0 during a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | 1 selects programming mode (flag reads), 0 selects ROM-read mode |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | 0 none, 1 program, 2 erase, 3 clear time-limit flag |
| cmd_msb | input | 1 | Bit 7 of the byte being programmed |
| cfg_prog_cyc | input | CNT_W | Program busy length in cycles |
| cfg_erase_cyc | input | CNT_W | Erase busy length in cycles |
| cfg_limit | input | CNT_W | Busy cycles allowed before the time-limit flag sets |
| rd_req | input | 1 | Read strobe |
| rd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| rd_addr_lsb | input | 1 | Address bit 0 of the read |
| arr_rdata | input | BUS_W | Data from the array |
| rd_data | output | BUS_W | Read data returned to the bus |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 2 clears pending (write 1), bit 1 is the enable |
| ctl_rdata | output | 3 | {pending, enable, ready} |
| rdy | output | 1 | Ready/busy line, low while busy |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the properties that stay true at any point in time. These are the ready bit mirror, the irq gating, pending being set on each ready rise, rdy dropping after an accepted command, array pass-through when idle or in ROM mode, zero upper byte and reserved bits on flag reads, blank word reads, and the time-limit flag holding until a clear. Some behaviours depend on history and need the bench scenarios. These are the exact busy length, toggle sequences across successive reads, data-polling values, commands ignored while busy, and time-limit carry-over across sequences. The bench compares these against a cycle-counted model.

// File: rtl/flash_algo_status_pkg.sv
package flash_algo_status_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_PROG  = 2'd1,
    CMD_ERASE = 2'd2,
    CMD_CLR   = 2'd3
  } cmd_e;

  typedef struct packed {
    logic dpoll;
    logic tog;
    logic tlim;
    logic rsv4;
    logic etmr;
    logic tog2;
    logic rsv1;
    logic rsv0;
  } flags_t;
endpackage

// File: rtl/flash_algo_seq.sv
module flash_algo_seq
  import flash_algo_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_msb,
  input  logic [CNT_W-1:0] cfg_prog_cyc,
  input  logic [CNT_W-1:0] cfg_erase_cyc,
  input  logic [CNT_W-1:0] cfg_limit,
  output logic             busy,
  output logic             erase_op,
  output logic             poll_bit,
  output logic             tl_flag,
  output logic             start,
  output logic             done
);
  logic             busy_q, busy_n;
  logic             erase_q, erase_n;
  logic             msb_q, msb_n;
  logic             tl_q, tl_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] el_q, el_n;
  logic [CNT_W-1:0] load_raw, load_val;
  logic             accept, run_en;

  always_comb begin
    accept   = cmd_valid && !busy_q &&
               (cmd_kind == CMD_PROG || cmd_kind == CMD_ERASE);
    load_raw = (cmd_kind == CMD_ERASE) ? cfg_erase_cyc : cfg_prog_cyc;
    load_val = (load_raw == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : load_raw;
    run_en   = accept || busy_q;
  end

  // next state of the sequence
  always_comb begin
    busy_n  = busy_q;
    erase_n = erase_q;
    msb_n   = msb_q;
    cnt_n   = cnt_q;
    el_n    = el_q;
    if (accept) begin
      busy_n  = 1'b1;
      cnt_n   = load_val;
      el_n    = '0;
      erase_n = (cmd_kind == CMD_ERASE);
      msb_n   = (cmd_kind == CMD_ERASE) ? 1'b1 : cmd_msb;
    end else if (busy_q) begin
      if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) busy_n = 1'b0;
      else cnt_n = cnt_q - 1'b1;
      if (el_q != '1) el_n = el_q + 1'b1;
    end
  end

  always_comb begin
    tl_n = tl_q;
    if (cmd_valid && cmd_kind == CMD_CLR) tl_n = 1'b0;
    else if (busy_q && el_q >= cfg_limit) tl_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      msb_q   <= 1'b0;
      cnt_q   <= '0;
      el_q    <= '0;
      tl_q    <= 1'b0;
    end else begin
      tl_q <= tl_n;
      if (run_en) begin
        busy_q  <= busy_n;
        erase_q <= erase_n;
        msb_q   <= msb_n;
        cnt_q   <= cnt_n;
        el_q    <= el_n;
      end
    end
  end

  assign busy     = busy_q;
  assign erase_op = erase_q;
  assign poll_bit = ~msb_q;
  assign tl_flag  = tl_q;
  assign start    = accept;
  assign done     = busy_q && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/flash_algo_flags.sv
module flash_algo_flags
  import flash_algo_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             erase_op,
  input  logic             poll_bit,
  input  logic             tl_flag,
  input  logic             start,
  input  logic             prog_mode,
  input  logic             rd_req,
  input  logic [1:0]       rd_size,
  input  logic             rd_addr_lsb,
  input  logic [BUS_W-1:0] arr_rdata,
  output logic [BUS_W-1:0] rd_data
);
  logic   tog_q, tog_n, tog2_q, tog2_n;
  logic   gated, flag_rd;
  flags_t flags;

  always_comb begin
    gated   = busy && prog_mode;
    flag_rd = rd_req && gated &&
              (rd_size == 2'd1 || (rd_size == 2'd0 && rd_addr_lsb));
    flags       = '0;
    flags.dpoll = poll_bit;
    flags.tog   = tog_q;
    flags.tlim  = tl_flag;
    flags.etmr  = erase_op;
    flags.tog2  = tog2_q;
    if (!gated)       rd_data = arr_rdata;
    else if (flag_rd) rd_data = {{(BUS_W-8){1'b0}}, flags};
    else              rd_data = '0;
  end

  always_comb begin
    tog_n  = tog_q;
    tog2_n = tog2_q;
    if (start) begin
      tog_n  = 1'b0;
      tog2_n = 1'b0;
    end else if (flag_rd) begin
      tog_n  = ~tog_q;
      tog2_n = tog2_q ^ erase_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      tog2_q <= 1'b0;
    end else if (start || flag_rd) begin
      tog_q  <= tog_n;
      tog2_q <= tog2_n;
    end
  end
endmodule

// File: rtl/flash_algo_irq.sv
module flash_algo_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic       ctl_we,
  input  logic [2:1] ctl_wdata,
  output logic       ie,
  output logic       pend,
  output logic       irq
);
  logic ie_q, ie_n, pend_q, pend_n;

  always_comb begin
    ie_n   = ctl_we ? ctl_wdata[1] : ie_q;
    pend_n = pend_q;
    if (done) pend_n = 1'b1;
    else if (ctl_we && ctl_wdata[2]) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_we) ie_q <= ie_n;
      if (done || ctl_we) pend_q <= pend_n;
    end
  end

  assign ie   = ie_q;
  assign pend = pend_q;
  assign irq  = ie_q && pend_q;
endmodule

// File: rtl/flash_algo_status.sv
module flash_algo_status
  import flash_algo_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_mode,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_msb,
  input  logic [CNT_W-1:0] cfg_prog_cyc,
  input  logic [CNT_W-1:0] cfg_erase_cyc,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             rd_req,
  input  logic [1:0]       rd_size,
  input  logic             rd_addr_lsb,
  input  logic [BUS_W-1:0] arr_rdata,
  output logic [BUS_W-1:0] rd_data,
  input  logic             ctl_we,
  input  logic [2:1]       ctl_wdata,
  output logic [2:0]       ctl_rdata,
  output logic             rdy,
  output logic             irq
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       busy, erase_op, poll_bit, tl_flag, start, done, ie, pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  flash_algo_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_msb(cmd_msb), .cfg_prog_cyc(cfg_prog_cyc), .cfg_erase_cyc(cfg_erase_cyc),
    .cfg_limit(cfg_limit), .busy(busy), .erase_op(erase_op), .poll_bit(poll_bit),
    .tl_flag(tl_flag), .start(start), .done(done)
  );

  flash_algo_flags flags_i (
    .clk(clk), .rst_n(rst_int_n), .busy(busy), .erase_op(erase_op),
    .poll_bit(poll_bit), .tl_flag(tl_flag), .start(start), .prog_mode(prog_mode),
    .rd_req(rd_req), .rd_size(rd_size), .rd_addr_lsb(rd_addr_lsb),
    .arr_rdata(arr_rdata), .rd_data(rd_data)
  );

  flash_algo_irq irq_i (
    .clk(clk), .rst_n(rst_int_n), .done(done), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ie(ie), .pend(pend), .irq(irq)
  );

  assign rdy       = ~busy;
  assign ctl_rdata = {pend, ie, rdy};
endmodule

// File: rtl/flash_algo_status_chk.sv
module flash_algo_status_chk
  import flash_algo_status_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             prog_mode,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic             rd_req,
  input logic [1:0]       rd_size,
  input logic [BUS_W-1:0] arr_rdata,
  input logic [BUS_W-1:0] rd_data,
  input logic [2:0]       ctl_rdata,
  input logic             rdy,
  input logic             irq,
  input logic             tl_flag
);
  p_accept_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rdy && (cmd_kind == CMD_PROG || cmd_kind == CMD_ERASE)) |=> !rdy);

  p_ready_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] == rdy);

  p_pend_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ctl_rdata[2]);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ctl_rdata[1] && ctl_rdata[2]));

  p_flag_format_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && prog_mode && rd_req && rd_size == 2'd1) |->
      (rd_data[BUS_W-1:8] == '0 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

  p_word_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && prog_mode && rd_req && rd_size == 2'd2) |-> rd_data == '0);

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy || !prog_mode) |-> rd_data == arr_rdata);

  p_tl_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tl_flag && !(cmd_valid && cmd_kind == CMD_CLR)) |=> tl_flag);
endmodule

bind flash_algo_status flash_algo_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .rd_req(rd_req), .rd_size(rd_size), .arr_rdata(arr_rdata),
  .rd_data(rd_data), .ctl_rdata(ctl_rdata), .rdy(rdy), .irq(irq), .tl_flag(tl_flag)
);

// File: tb/flash_algo_status_tb_top.sv
module flash_algo_status_tb_top;
  localparam int CW = 16;

  logic          clk, rst_n, prog_mode, cmd_valid, cmd_msb;
  logic [1:0]    cmd_kind, rd_size;
  logic [CW-1:0] cfg_prog_cyc, cfg_erase_cyc, cfg_limit;
  logic          rd_req, rd_addr_lsb, ctl_we, rdy, irq;
  logic [15:0]   arr_rdata, rd_data;
  logic [2:1]    ctl_wdata;
  logic [2:0]    ctl_rdata;

  int n_tests, n_fail;
  bit finished;
  logic m_tog, m_tog2, m_tl, m_ie;

  flash_algo_status #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_msb(cmd_msb), .cfg_prog_cyc(cfg_prog_cyc),
    .cfg_erase_cyc(cfg_erase_cyc), .cfg_limit(cfg_limit), .rd_req(rd_req),
    .rd_size(rd_size), .rd_addr_lsb(rd_addr_lsb), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rdy(rdy), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mk_flags(logic dp, logic tg, logic tl, logic et, logic tg2);
    return {dp, tg, tl, 1'b0, et, tg2, 2'b00};
  endfunction

  function automatic logic [15:0] exp_rd(logic pm, logic bsy, logic [1:0] sz, logic lsb,
                                         logic [7:0] fl, logic [15:0] arr);
    if (!(pm && bsy)) return arr;
    if (sz == 2'd1 || (sz == 2'd0 && lsb)) return {8'h00, fl};
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rand_read();
    rd_req      = 1'b1;
    rd_size     = 2'($urandom % 3);
    rd_addr_lsb = 1'($urandom % 2);
    arr_rdata   = 16'($urandom);
  endtask

  task automatic clear_tl();
    cmd_valid = 1'b1; cmd_kind = 2'd3;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 2'd0;
    m_tl = 1'b0;
  endtask

  task automatic run_op(input logic er, input logic msb, input logic pm,
                        input int dur, input int lim, input bit poke);
    int d;
    logic st;
    logic [7:0] fl;
    d = (dur == 0) ? 1 : dur;
    cfg_prog_cyc = CW'(dur); cfg_erase_cyc = CW'(dur); cfg_limit = CW'(lim);
    prog_mode = pm;
    cmd_valid = 1'b1; cmd_kind = er ? 2'd2 : 2'd1; cmd_msb = msb;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 2'd0;
    m_tog = 1'b0; m_tog2 = 1'b0;
    for (int n = 1; n <= d; n++) begin
      rand_read();
      if (poke && n == 1) begin
        cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_msb = ~msb;   // R4: must be ignored
      end
      #1;
      chk("R1 busy", {15'd0, rdy}, 16'd0);
      chk("R2 ready bit", {15'd0, ctl_rdata[0]}, 16'd0);
      fl = mk_flags(er ? 1'b0 : ~msb, m_tog, m_tl || (n >= lim + 2), er, m_tog2);
      chk(pm ? "R5 R6 R7 R9 R10 R4 flag read" : "R8 rom mode", rd_data,
          exp_rd(pm, 1'b1, rd_size, rd_addr_lsb, fl, arr_rdata));
      st = pm && (rd_size == 2'd1 || (rd_size == 2'd0 && rd_addr_lsb));
      if (st) begin
        m_tog = ~m_tog;
        if (er) m_tog2 = ~m_tog2;
      end
      @(negedge clk);
      cmd_valid = 1'b0; cmd_kind = 2'd0;
    end
    m_tl = m_tl || (d >= lim + 1);
    rand_read();
    #1;
    chk("R1 ready after count", {15'd0, rdy}, 16'd1);
    chk("R8 idle passthrough", rd_data, arr_rdata);
    chk("R3 pending set", {15'd0, ctl_rdata[2]}, 16'd1);
    chk("R3 irq gated", {15'd0, irq}, {15'd0, m_ie});
    ctl_we = 1'b1; ctl_wdata = {1'b1, m_ie};
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = 2'b00;
    #1;
    chk("R3 pending cleared", {13'd0, ctl_rdata}, {13'd0, 1'b0, m_ie, 1'b1});
    chk("R3 irq low", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    finished = 0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    n_tests = 0; n_fail = 0;
    m_tog = 0; m_tog2 = 0; m_tl = 0; m_ie = 0;
    rst_n = 1'b0; prog_mode = 1'b1; cmd_valid = 1'b0; cmd_kind = 2'd0; cmd_msb = 1'b0;
    cfg_prog_cyc = '0; cfg_erase_cyc = '0; cfg_limit = 16'd100;
    rd_req = 1'b0; rd_size = 2'd1; rd_addr_lsb = 1'b0; arr_rdata = 16'hA5C3;
    ctl_we = 1'b0; ctl_wdata = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R2 reset state", {13'd0, ctl_rdata}, 16'd1);
    chk("R1 reset ready", {15'd0, rdy}, 16'd1);
    chk("R3 reset irq", {15'd0, irq}, 16'd0);
    chk("R8 reset passthrough", rd_data, 16'hA5C3);

    // enable interrupt
    ctl_we = 1'b1; ctl_wdata = 2'b01; m_ie = 1'b1;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;

    run_op(1'b0, 1'b1, 1'b1, 0, 100, 0);   // R1 zero count acts as one
    run_op(1'b0, 1'b0, 1'b1, 5, 100, 1);   // R4 command while busy
    run_op(1'b1, 1'b0, 1'b1, 7, 100, 1);   // R10 R7 erase
    run_op(1'b0, 1'b1, 1'b0, 4, 100, 0);   // R8 ROM mode
    run_op(1'b0, 1'b0, 1'b1, 6, 3, 0);     // R9 overrun sets flag
    run_op(1'b1, 1'b1, 1'b1, 3, 100, 0);   // R9 flag still set
    clear_tl();
    run_op(1'b0, 1'b1, 1'b1, 2, 100, 0);   // R9 cleared
    run_op(1'b0, 1'b0, 1'b1, 4, 3, 0);     // R9 boundary: exactly limit+1

    // interrupt disabled: pending still sets, irq stays low
    ctl_we = 1'b1; ctl_wdata = 2'b00; m_ie = 1'b0;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;
    clear_tl();
    run_op(1'b0, 1'b1, 1'b1, 3, 3, 0);     // R9 boundary: exactly limit, no set

    for (int k = 0; k < 24; k++) begin
      if (k == 12) begin
        ctl_we = 1'b1; ctl_wdata = 2'b01; m_ie = 1'b1;
        @(posedge clk); @(negedge clk);
        ctl_we = 1'b0;
      end
      run_op(1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 4) != 0),
             1 + int'($urandom % 12), 4 + int'($urandom % 12), bit'($urandom % 2));
      if (m_tl && ($urandom % 2 == 0)) clear_tl();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule